// File: doc/BRIEF.md
# PLL Synthesizer Configuration Sequencer

This block keeps the settings of an external reference-divider PLL chip and writes them into it over a write-only serial link. The link has a clock, a data line and a latch strobe. The settings are packed into four 24-bit latch words. The block shifts each word out with the most significant bit first and raises the latch strobe once after each word. One programming pass always sends the words in the same order. The control word goes out twice, first under the initialization address and then under the function address. The reference-divider word follows, and the feedback-divider word comes last.

A pass starts by itself when reset is released. It also starts whenever the external-reference select input changes level, and whenever software pulses the start request. When the override enable is high, the divider and charge-pump current values come from the override inputs. When it is low, the parameterized defaults are used. All settings are captured in the cycle the pass is accepted and stay fixed until the pass ends. A request that arrives during a pass is held and served after the pass ends.

Top module: `pll_cfg_seq`

## Requirements
- R1: Each frame is 24 bits, sent most significant bit first. `spi_mosi` is set while `spi_sclk` is low and does not change while `spi_sclk` is high, so the chip can sample it on the rising edge.
- R2: Bits [1:0] of every frame hold the latch address. A pass sends addresses 3, 2, 0 and 1, in that order.
- R3: The words at addresses 3 and 2 are identical apart from bits [1:0]. Their fields are:
  - bit 8 = charge-pump tristate, 1 = tristate and 0 = normal;
  - [17:15] = charge-pump current 1, and [20:18] = charge-pump current 2;
  - bit 7 = 1, for positive phase-detector polarity;
  - [6:4] = 3'b001, the lock-detect output selection;
  - every other bit is 0.
- R4: The address-0 word carries the 14-bit reference divider at [15:2]. All other bits are 0 (anti-backlash code 0 and lock-detect precision code 0).
- R5: The address-1 word carries the 13-bit feedback divider at [20:8]. All other bits are 0 apart from the address, so charge-pump gain code 0 is at bit 21.
- R6: Serial timing, with D = DIV_HALF system clocks:
  - each bit lasts one serial-clock period, `spi_sclk` low for D clocks and then high for D clocks;
  - after the 24th bit, `spi_le` is high for 2·D clocks while `spi_sclk` is low;
  - `spi_le` and `spi_sclk` are never high together;
  - the first bit starts the cycle after the pass is accepted.
- R7: After reset, `busy` is high and the serial outputs are low. A pass with the defaults (R=1, N=4, both currents 7) runs without any request.
- R8: Any level change on `ext_ref_sel` starts a pass. Bit 8 of the control words is the inverse of the `ext_ref_sel` value captured at acceptance.
- R9: A one-cycle `start_req` starts a pass. With `ovr_en` high at acceptance, the pass uses `ovr_ref_div`, `ovr_n_div`, `ovr_cp1` and `ovr_cp2`.
- R10: `busy` rises the clock after a request and stays high until the address-1 word has been latched. `pass_done` pulses for one clock as `busy` falls.
- R11: A request during a pass is held, and one more pass follows after a single idle clock. Any number of requests during a pass yield one extra pass. A request in the acceptance cycle itself is absorbed into the pass being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Reprogram request pulse |
| ext_ref_sel | input | 1 | 1 = lock to external reference |
| ovr_en | input | 1 | Use override values instead of defaults |
| ovr_ref_div | input | 14 | Override reference divider |
| ovr_n_div | input | 13 | Override feedback divider |
| ovr_cp1 | input | 3 | Override charge-pump current 1 |
| ovr_cp2 | input | 3 | Override charge-pump current 2 |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data |
| spi_le | output | 1 | Latch-enable strobe |
| busy | output | 1 | Request pending or pass running |
| pass_done | output | 1 | One-clock pulse at the end of a pass |

## Verification
A new request can land in the same clock as the acceptance of a pending pass, or in the last clock of a running pass. In the first case the request must be absorbed. In the second case it must be queued as one more pass. The bench provokes the first case by pulsing `start_req` on two consecutive clocks while idle, and by changing `ext_ref_sel` one clock after a start pulse. It then checks that exactly four words arrive and that they carry the new select value. A behavioural model runs next to the design, and its `busy` and `pass_done` values are compared with the design on every clock. Queued passes are judged by the word count and the field values of the extra pass.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int FRAME_W = 24;
  localparam int NUM_FRM = 4;
  localparam int RDIV_W  = 14;
  localparam int NDIV_W  = 13;
  localparam int CP_W    = 3;

  localparam logic [2:0] MUX_LOCK  = 3'd1;
  localparam logic       PD_POS    = 1'b1;
  localparam logic       CNT_RUN   = 1'b0;
  localparam logic [1:0] PWR_ON    = 2'b00;
  localparam logic [1:0] FL_OFF    = 2'b00;
  localparam logic [3:0] TMR_CODE  = 4'd0;
  localparam logic [1:0] ABW_CODE  = 2'd0;
  localparam logic       LDP_CODE  = 1'b0;
  localparam logic       CPG_CODE  = 1'b0;

  typedef struct packed {
    logic [RDIV_W-1:0] rdiv;
    logic [NDIV_W-1:0] ndiv;
    logic [CP_W-1:0]   cp1;
    logic [CP_W-1:0]   cp2;
    logic              ext;
  } cfg_t;

  // Address sent in each slot of a pass; the order is behaviour.
  function automatic logic [1:0] slot_addr(input int slot);
    case (slot)
      0:       slot_addr = 2'd3;
      1:       slot_addr = 2'd2;
      2:       slot_addr = 2'd0;
      default: slot_addr = 2'd1;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] ctrl_word(input cfg_t c, input logic [1:0] a);
    logic [FRAME_W-1:0] w;
    w        = '0;
    w[1:0]   = a;
    w[2]     = CNT_RUN;
    w[3]     = PWR_ON[0];
    w[6:4]   = MUX_LOCK;
    w[7]     = PD_POS;
    w[8]     = ~c.ext;
    w[10:9]  = FL_OFF;
    w[14:11] = TMR_CODE;
    w[17:15] = c.cp1;
    w[20:18] = c.cp2;
    w[21]    = PWR_ON[1];
    return w;
  endfunction

  function automatic logic [FRAME_W-1:0] ref_word(input cfg_t c);
    logic [FRAME_W-1:0] w;
    w        = '0;
    w[1:0]   = 2'd0;
    w[15:2]  = c.rdiv;
    w[17:16] = ABW_CODE;
    w[20]    = LDP_CODE;
    return w;
  endfunction

  function automatic logic [FRAME_W-1:0] fb_word(input cfg_t c);
    logic [FRAME_W-1:0] w;
    w        = '0;
    w[1:0]   = 2'd1;
    w[20:8]  = c.ndiv;
    w[21]    = CPG_CODE;
    return w;
  endfunction
endpackage

// File: rtl/pll_cfg_req.sv
module pll_cfg_req (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic ext_ref_sel,
  input  logic take,
  output logic pend,
  output logic trig
);
  logic sel_prev_q;
  logic pend_q;

  assign trig = start_req | (ext_ref_sel != sel_prev_q);
  assign pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q <= 1'b0;
      pend_q     <= 1'b1;
    end else begin
      sel_prev_q <= ext_ref_sel;
      if (take) pend_q <= 1'b0;
      else      pend_q <= pend_q | trig;
    end
  end

  a_r11_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take |=> pend_q);
  a_r11_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend_q);
endmodule

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
  import pll_cfg_pkg::*;
#(
  parameter int R_DEF  = 1,
  parameter int N_DEF  = 4,
  parameter int CP_DEF = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             take,
  input  logic                             ext_ref_sel,
  input  logic                             ovr_en,
  input  logic [RDIV_W-1:0]                ovr_ref_div,
  input  logic [NDIV_W-1:0]                ovr_n_div,
  input  logic [CP_W-1:0]                  ovr_cp1,
  input  logic [CP_W-1:0]                  ovr_cp2,
  output logic [NUM_FRM-1:0][FRAME_W-1:0]  words
);
  localparam cfg_t CFG_DEF = '{rdiv: RDIV_W'(R_DEF), ndiv: NDIV_W'(N_DEF),
                               cp1: CP_W'(CP_DEF), cp2: CP_W'(CP_DEF), ext: 1'b0};
  cfg_t snap_q, snap_d;

  always_comb begin
    snap_d     = CFG_DEF;
    snap_d.ext = ext_ref_sel;
    if (ovr_en) begin
      snap_d.rdiv = ovr_ref_div;
      snap_d.ndiv = ovr_n_div;
      snap_d.cp1  = ovr_cp1;
      snap_d.cp2  = ovr_cp2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= CFG_DEF;
    else if (take) snap_q <= snap_d;
  end

  for (genvar s = 0; s < NUM_FRM; s++) begin : g_slot
    if (s < 2) begin : g_ctrl
      assign words[s] = ctrl_word(snap_q, slot_addr(s));
    end else if (s == 2) begin : g_ref
      assign words[s] = ref_word(snap_q);
    end else begin : g_fb
      assign words[s] = fb_word(snap_q);
    end
  end

  a_r3_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(snap_q));
endmodule

// File: rtl/pll_cfg_ser.sv
module pll_cfg_ser
  import pll_cfg_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [NUM_FRM-1:0][FRAME_W-1:0] words,
  output logic                            active,
  output logic                            pass_end,
  output logic                            sclk,
  output logic                            mosi,
  output logic                            le
);
  localparam int HALVES = 2 * FRAME_W + 2;
  localparam int HW     = $clog2(HALVES);
  localparam int DW     = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int FW     = $clog2(NUM_FRM);

  logic          act_q;
  logic [DW-1:0] div_q;
  logic [HW-1:0] half_q;
  logic [FW-1:0] frm_q;
  logic          end_q;

  logic half_last, frame_last, pass_last, in_le;
  logic [4:0] bpos;
  logic [FRAME_W-1:0] cur_word;

  assign half_last  = div_q == DW'(DIV_HALF - 1);
  assign frame_last = half_q == HW'(HALVES - 1);
  assign pass_last  = frm_q == FW'(NUM_FRM - 1);
  assign in_le      = half_q >= HW'(2 * FRAME_W);
  assign bpos       = 5'(FRAME_W - 1) - 5'(half_q >> 1);
  assign cur_word   = words[frm_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      div_q  <= '0;
      half_q <= '0;
      frm_q  <= '0;
      end_q  <= 1'b0;
    end else begin
      end_q <= act_q & half_last & frame_last & pass_last;
      if (!act_q) begin
        if (load) begin
          act_q  <= 1'b1;
          div_q  <= '0;
          half_q <= '0;
          frm_q  <= '0;
        end
      end else if (half_last) begin
        div_q <= '0;
        if (frame_last) begin
          half_q <= '0;
          if (pass_last) act_q <= 1'b0;
          else           frm_q <= frm_q + 1'b1;
        end else begin
          half_q <= half_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign active   = act_q;
  assign pass_end = end_q;
  assign sclk     = act_q & ~in_le & half_q[0];
  assign le       = act_q & in_le;
  assign mosi     = act_q & ~in_le & cur_word[bpos];

  a_r6_le_sclk_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(le && sclk));
  a_r1_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sclk && $past(sclk) |-> $stable(mosi));
  a_r2_frame_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && $past(act_q) && (frm_q != $past(frm_q)) |-> $past(le));
  a_r10_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> $past(le) && !act_q);
endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
  import pll_cfg_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int R_DEF    = 1,
  parameter int N_DEF    = 4,
  parameter int CP_DEF   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        ext_ref_sel,
  input  logic        ovr_en,
  input  logic [13:0] ovr_ref_div,
  input  logic [12:0] ovr_n_div,
  input  logic [2:0]  ovr_cp1,
  input  logic [2:0]  ovr_cp2,
  output logic        spi_sclk,
  output logic        spi_mosi,
  output logic        spi_le,
  output logic        busy,
  output logic        pass_done
);
  logic pend, trig, take, active;
  logic [NUM_FRM-1:0][FRAME_W-1:0] words;

  assign take = pend & ~active;
  assign busy = pend | active;

  pll_cfg_req u_req (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ext_ref_sel(ext_ref_sel),
    .take(take), .pend(pend), .trig(trig)
  );

  pll_cfg_bank #(.R_DEF(R_DEF), .N_DEF(N_DEF), .CP_DEF(CP_DEF)) u_bank (
    .clk(clk), .rst_n(rst_n), .take(take), .ext_ref_sel(ext_ref_sel),
    .ovr_en(ovr_en), .ovr_ref_div(ovr_ref_div), .ovr_n_div(ovr_n_div),
    .ovr_cp1(ovr_cp1), .ovr_cp2(ovr_cp2), .words(words)
  );

  pll_cfg_ser #(.DIV_HALF(DIV_HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(take), .words(words), .active(active),
    .pass_end(pass_done), .sclk(spi_sclk), .mosi(spi_mosi), .le(spi_le)
  );

  a_r10_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk && !spi_le);
  a_r10_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy);
endmodule

// File: tb/pll_cfg_seq_test.sv
module pll_cfg_seq_test;
  localparam int D = 2;
  localparam int FRM_CYC = 50 * D;
  localparam int PASS_CYC = 4 * FRM_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, ext_ref_sel = 1'b0, ovr_en = 1'b0;
  logic [13:0] ovr_ref_div = '0;
  logic [12:0] ovr_n_div = '0;
  logic [2:0]  ovr_cp1 = '0, ovr_cp2 = '0;
  logic spi_sclk, spi_mosi, spi_le, busy, pass_done;

  always #2 clk = ~clk;

  pll_cfg_seq #(.DIV_HALF(D)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ext_ref_sel(ext_ref_sel),
    .ovr_en(ovr_en), .ovr_ref_div(ovr_ref_div), .ovr_n_div(ovr_n_div),
    .ovr_cp1(ovr_cp1), .ovr_cp2(ovr_cp2), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_le(spi_le), .busy(busy), .pass_done(pass_done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit fin = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up;
    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic int exp_ctrl(int tri_cp, int c1, int c2, int a);
    return a + 16 + 128 + tri_cp * 256 + c1 * 32768 + c2 * 262144;
  endfunction
  function automatic int exp_ref(int r); return r * 4; endfunction
  function automatic int exp_fb(int n); return n * 256 + 1; endfunction

  // Behavioural reference: one pass counter, words fixed at acceptance.
  int m_pend, m_act, m_cnt, m_prev, m_done;
  int m_w[4];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 1; m_act = 0; m_cnt = 0; m_prev = 0; m_done = 0;
    end else begin
      int trg;
      trg = (start_req || (int'(ext_ref_sel) != m_prev)) ? 1 : 0;
      m_done = 0;
      if (m_act != 0) begin
        if (m_cnt == PASS_CYC - 1) begin m_act = 0; m_done = 1; end
        else m_cnt++;
        if (trg != 0) m_pend = 1;
      end else if (m_pend != 0) begin
        int r, n, c1, c2, t;
        r  = ovr_en ? int'(ovr_ref_div) : 1;
        n  = ovr_en ? int'(ovr_n_div) : 4;
        c1 = ovr_en ? int'(ovr_cp1) : 7;
        c2 = ovr_en ? int'(ovr_cp2) : 7;
        t  = ext_ref_sel ? 0 : 1;
        m_w[0] = exp_ctrl(t, c1, c2, 3);
        m_w[1] = exp_ctrl(t, c1, c2, 2);
        m_w[2] = exp_ref(r);
        m_w[3] = exp_fb(n);
        m_act = 1; m_cnt = 0; m_pend = 0;
      end else if (trg != 0) begin
        m_pend = 1;
      end
      m_prev = int'(ext_ref_sel);
    end
  end

  // Per-clock comparison and frame capture from the serial pins.
  int cap_q[$];
  int sh = 0, nbits = 0, p_sclk = 0, p_le = 0;
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      int e_sclk, e_mosi, e_le, fr, hf;
      e_sclk = 0; e_mosi = 0; e_le = 0;
      if (m_act != 0) begin
        fr = m_cnt / FRM_CYC;
        hf = (m_cnt % FRM_CYC) / D;
        if (hf < 48) begin
          e_sclk = hf % 2;
          e_mosi = (m_w[fr] >> (23 - hf / 2)) & 1;
        end else e_le = 1;
      end
      chk("R6 sclk", int'(spi_sclk), e_sclk);
      chk("R1 mosi", int'(spi_mosi), e_mosi);
      chk("R6 le", int'(spi_le), e_le);
      chk("R10 busy", int'(busy), (m_pend != 0 || m_act != 0) ? 1 : 0);
      chk("R10 pass_done", int'(pass_done), m_done);
      if (spi_sclk && p_sclk == 0) begin sh = (sh << 1) | int'(spi_mosi); nbits++; end
      if (spi_le && p_le == 0) begin
        chk("R1 bits per frame", nbits, 24);
        cap_q.push_back(sh & 24'hFFFFFF);
        sh = 0; nbits = 0;
      end
      p_sclk = int'(spi_sclk); p_le = int'(spi_le);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      wrap_up();
    end
  end

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start;
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
  endtask

  task automatic check_pass(input string req, input int t, input int r, input int n,
                            input int c1, input int c2);
    int w;
    chk({req, " R2 words available"}, (cap_q.size() >= 4) ? 1 : 0, 1);
    if (cap_q.size() >= 4) begin
      w = cap_q.pop_front(); chk({req, " R2 R3 init word"}, w, exp_ctrl(t, c1, c2, 3));
      chk({req, " R2 addr slot0"}, w & 3, 3);
      w = cap_q.pop_front(); chk({req, " R2 R3 func word"}, w, exp_ctrl(t, c1, c2, 2));
      w = cap_q.pop_front(); chk({req, " R2 R4 ref word"}, w, exp_ref(r));
      w = cap_q.pop_front(); chk({req, " R2 R5 fb word"}, w, exp_fb(n));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 reset sclk", int'(spi_sclk), 0);
    chk("R7 reset le", int'(spi_le), 0);
    chk("R7 reset mosi", int'(spi_mosi), 0);
    chk("R7 reset busy", int'(busy), 1);
    rst_n = 1'b1;
    wait_idle();
    check_pass("R7 default pass", 1, 1, 4, 7, 7);
    chk("R7 one pass only", cap_q.size(), 0);

    // R8 select external reference
    ext_ref_sel = 1'b1;
    wait_idle();
    check_pass("R8 external", 0, 1, 4, 7, 7);
    ext_ref_sel = 1'b0;
    wait_idle();
    check_pass("R8 internal", 1, 1, 4, 7, 7);

    // R9 overrides with start request
    ovr_en = 1'b1; ovr_ref_div = 14'h3FFF; ovr_n_div = 13'h1ABC; ovr_cp1 = 3'd2; ovr_cp2 = 3'd5;
    pulse_start();
    wait_idle();
    check_pass("R9 override", 1, 16383, 6844, 2, 5);
    ovr_ref_div = 14'h2001; ovr_n_div = 13'h0001; ovr_cp1 = 3'd0; ovr_cp2 = 3'd7;
    ext_ref_sel = 1'b1;
    wait_idle();
    check_pass("R9 R8 override ext", 0, 8193, 1, 0, 7);
    ovr_en = 1'b0;

    // R11 requests during a pass: several collapse into one extra pass
    pulse_start();
    repeat (50) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    ext_ref_sel = 1'b0;
    repeat (20) @(negedge clk);
    ext_ref_sel = 1'b1;
    wait_idle();
    check_pass("R11 first", 0, 1, 4, 7, 7);
    check_pass("R11 queued", 0, 1, 4, 7, 7);
    chk("R11 exactly two passes", cap_q.size(), 0);

    // R11 request in the acceptance cycle is absorbed
    pulse_start();
    pulse_start();
    wait_idle();
    check_pass("R11 absorbed start", 0, 1, 4, 7, 7);
    chk("R11 absorbed count", cap_q.size(), 0);
    pulse_start();
    ext_ref_sel = 1'b0;
    @(negedge clk);
    wait_idle();
    check_pass("R11 R8 absorbed select", 1, 1, 4, 7, 7);
    chk("R11 absorbed select count", cap_q.size(), 0);

    // R10 request on the final clock of a pass queues another pass
    pulse_start();
    @(negedge clk);
    while (!(spi_le && !busy) && !pass_done) begin
      if (uut.spi_le && cap_q.size() == 3 && m_cnt == PASS_CYC - 1) break;
      @(negedge clk);
    end
    pulse_start();
    wait_idle();
    chk("R10 R11 late request passes", cap_q.size(), 8);
    check_pass("R10 late a", 1, 1, 4, 7, 7);
    check_pass("R10 late b", 1, 1, 4, 7, 7);
    wrap_up();
  end
endmodule